// File: doc/BRIEF.md
# Register Rename Map Table

This block keeps, for every architectural register, a record of whether a younger instruction still in flight will produce it, and if so which reorder-buffer slot holds that producer. A rename stage presents a bundle of up to `LANES` instructions in program order. The block answers both source lookups of every lane in the same cycle. A mapped source gets the producer's tag and the current ready bit of that reorder-buffer slot. A source that is absent, or whose register has no live mapping, is reported ready with no tag.

Within a bundle, a later lane sees the destination of any earlier lane as its producer, so dependences inside the bundle come out correct. The destination mappings are written at the clock edge only when the bundle is presented and the reorder buffer has granted space for all of it. A retire port names the tag that leaves the reorder buffer. Any entry still pointing at that tag drops its mapping, unless the same edge writes a new mapping to that register.

Lookups read the table as it stood before the current edge. The outputs are combinational from the inputs and the stored table.

Top module: `rename_map`

## Requirements
- R1: After reset every entry is unmapped, so every present source with a register index below `ARCH_REGS` reports mapped=0, ready=1, tag=0.
- R2: A source whose use flag is 0, or whose entry is not valid, reports mapped=0, ready=1, tag=0.
- R3: A source whose entry is valid reports mapped=1, the stored tag, and ready equal to bit `tag` of `rob_ready_vec`.
- R4: When `ren_go` and `ren_grant` are both 1, each lane with `lane_vld`=1 and `dst_use`=1 makes its destination entry valid with that lane's `alloc_tag` from the next cycle.
- R5: A source of lane k whose register equals the destination of an earlier lane j<k (with `lane_vld[j]` and `dst_use[j]` set) reports mapped=1, tag=`alloc_tag` of the latest such lane, and ready=0. When several lanes of a committed bundle write one register, the highest-numbered lane's tag is stored.
- R6: When `retire_vld` is 1, every valid entry whose tag equals `retire_tag` becomes invalid at the next edge. Entries holding other tags are unchanged.
- R7: When `ren_go` or `ren_grant` is 0 and no retire takes place, the table is left unchanged.
- R8: When a retire clear and a new mapping hit the same register at the same edge, the new mapping is kept.
- R9: Register indices at or above `ARCH_REGS` are never mapped. Such a source reports mapped=0, ready=1, tag=0, and such a destination writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_go | input | 1 | Rename bundle presented |
| ren_grant | input | 1 | Reorder buffer accepts the whole bundle |
| lane_vld | input | LANES | Lane holds an instruction |
| srca_use | input | LANES | First source present, per lane |
| srca_reg | input | LANES*RW | First source register, per lane |
| srcb_use | input | LANES | Second source present, per lane |
| srcb_reg | input | LANES*RW | Second source register, per lane |
| dst_use | input | LANES | Destination present, per lane |
| dst_reg | input | LANES*RW | Destination register, per lane |
| alloc_tag | input | LANES*TW | Reorder-buffer tag allocated to each lane |
| rob_ready_vec | input | ROB_ENTRIES | Ready bit of every reorder-buffer slot |
| retire_vld | input | 1 | A tag retires this cycle |
| retire_tag | input | TW | Retiring tag |
| srca_mapped | output | LANES | First source has a producer |
| srca_tag | output | LANES*TW | First source producer tag |
| srca_rdy | output | LANES | First source ready |
| srcb_mapped | output | LANES | Second source has a producer |
| srcb_tag | output | LANES*TW | Second source producer tag |
| srcb_rdy | output | LANES | Second source ready |

## Verification
The bench builds the block with its defaults: 67 registers, 16 reorder-buffer slots and a two-lane bundle. The 7-bit register field then reaches indices 67 to 127, which exercises the out-of-range rule. With only 16 tags, random retires often hit live mappings, and tags alias across many registers. Because random registers are drawn mostly from a small pool, the two lanes often collide, which covers forwarding inside a bundle, same-destination writes and retire-versus-write conflicts.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
    localparam int DEF_ARCH_REGS   = 67;
    localparam int DEF_ROB_ENTRIES = 16;
    localparam int DEF_LANES       = 2;
endpackage

// File: rtl/rmt_table.sv
module rmt_table #(
    parameter int NUM   = rmt_pkg::DEF_ARCH_REGS,
    parameter int TW    = 4,
    parameter int LANES = rmt_pkg::DEF_LANES,
    parameter int RW    = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit,
    input  logic [LANES-1:0]               lane_vld,
    input  logic [LANES-1:0]               dst_use,
    input  logic [LANES-1:0][RW-1:0]       dst_reg,
    input  logic [LANES-1:0][TW-1:0]       alloc_tag,
    input  logic                           retire_vld,
    input  logic [TW-1:0]                  retire_tag,
    output logic [NUM-1:0]                 ent_valid,
    output logic [NUM-1:0][TW-1:0]         ent_tag
);
    typedef struct packed {
        logic [NUM-1:0]         valid;
        logic [NUM-1:0][TW-1:0] tag;
    } table_t;

    table_t         tbl_d, tbl_q;
    logic [NUM-1:0] wr_hit;

    always_comb begin
        tbl_d  = tbl_q;
        wr_hit = '0;
        for (int r = 0; r < NUM; r++) begin
            if (retire_vld && tbl_q.valid[r] && tbl_q.tag[r] == retire_tag) begin
                tbl_d.valid[r] = 1'b0;
            end
            for (int l = 0; l < LANES; l++) begin
                if (commit && lane_vld[l] && dst_use[l] && dst_reg[l] == RW'(r)) begin
                    wr_hit[r]      = 1'b1;
                    tbl_d.valid[r] = 1'b1;
                    tbl_d.tag[r]   = alloc_tag[l];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign ent_valid = tbl_q.valid;
    assign ent_tag   = tbl_q.tag;

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !retire_vld) |=> ($stable(ent_valid) && $stable(ent_tag)));

    for (genvar r = 0; r < NUM; r++) begin : g_ent
        assert_retire_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (retire_vld && ent_valid[r] && ent_tag[r] == retire_tag && !wr_hit[r])
            |=> !ent_valid[r]);
        assert_retire_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (retire_vld && ent_tag[r] != retire_tag && !wr_hit[r])
            |=> ($stable(ent_valid[r]) && $stable(ent_tag[r])));
        assert_new_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit[r] |=> ent_valid[r]);
        assert_map_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && lane_vld[LANES-1] && dst_use[LANES-1] && dst_reg[LANES-1] == RW'(r))
            |=> (ent_tag[r] == $past(alloc_tag[LANES-1])));
    end
endmodule

// File: rtl/rmt_lookup.sv
module rmt_lookup #(
    parameter int NUM   = rmt_pkg::DEF_ARCH_REGS,
    parameter int ROB   = rmt_pkg::DEF_ROB_ENTRIES,
    parameter int TW    = 4,
    parameter int LANES = rmt_pkg::DEF_LANES,
    parameter int RW    = 7,
    parameter int K     = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     src_use,
    input  logic [RW-1:0]            src_reg,
    input  logic [NUM-1:0]           ent_valid,
    input  logic [NUM-1:0][TW-1:0]   ent_tag,
    input  logic [ROB-1:0]           rob_rdy,
    input  logic [LANES-1:0]         lane_vld,
    input  logic [LANES-1:0]         dst_use,
    input  logic [LANES-1:0][RW-1:0] dst_reg,
    input  logic [LANES-1:0][TW-1:0] alloc_tag,
    output logic                     mapped,
    output logic [TW-1:0]            tag,
    output logic                     rdy
);
    always_comb begin
        mapped = 1'b0;
        tag    = '0;
        rdy    = 1'b1;
        if (src_use && src_reg < RW'(NUM)) begin
            if (ent_valid[src_reg]) begin
                mapped = 1'b1;
                tag    = ent_tag[src_reg];
                rdy    = rob_rdy[ent_tag[src_reg]];
            end
            for (int j = 0; j < K; j++) begin
                if (lane_vld[j] && dst_use[j] && dst_reg[j] == src_reg) begin
                    mapped = 1'b1;
                    tag    = alloc_tag[j];
                    rdy    = 1'b0;
                end
            end
        end
    end

    assert_absent_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !src_use |-> (rdy && !mapped && tag == '0));
    assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_reg >= RW'(NUM)) |-> (rdy && !mapped));
endmodule

// File: rtl/rename_map.sv
module rename_map #(
    parameter int ARCH_REGS   = rmt_pkg::DEF_ARCH_REGS,
    parameter int ROB_ENTRIES = rmt_pkg::DEF_ROB_ENTRIES,
    parameter int LANES       = rmt_pkg::DEF_LANES,
    localparam int TW         = $clog2(ROB_ENTRIES),
    localparam int RW         = $clog2(ARCH_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ren_go,
    input  logic                   ren_grant,
    input  logic [LANES-1:0]       lane_vld,
    input  logic [LANES-1:0]       srca_use,
    input  logic [LANES*RW-1:0]    srca_reg,
    input  logic [LANES-1:0]       srcb_use,
    input  logic [LANES*RW-1:0]    srcb_reg,
    input  logic [LANES-1:0]       dst_use,
    input  logic [LANES*RW-1:0]    dst_reg,
    input  logic [LANES*TW-1:0]    alloc_tag,
    input  logic [ROB_ENTRIES-1:0] rob_ready_vec,
    input  logic                   retire_vld,
    input  logic [TW-1:0]          retire_tag,
    output logic [LANES-1:0]       srca_mapped,
    output logic [LANES*TW-1:0]    srca_tag,
    output logic [LANES-1:0]       srca_rdy,
    output logic [LANES-1:0]       srcb_mapped,
    output logic [LANES*TW-1:0]    srcb_tag,
    output logic [LANES-1:0]       srcb_rdy
);
    logic [LANES-1:0][RW-1:0]     dst_reg_a, srca_reg_a, srcb_reg_a;
    logic [LANES-1:0][TW-1:0]     alloc_a;
    logic [ARCH_REGS-1:0]         ent_valid;
    logic [ARCH_REGS-1:0][TW-1:0] ent_tag;
    logic                         commit;

    assign dst_reg_a  = dst_reg;
    assign srca_reg_a = srca_reg;
    assign srcb_reg_a = srcb_reg;
    assign alloc_a    = alloc_tag;
    assign commit     = ren_go && ren_grant;

    rmt_table #(.NUM(ARCH_REGS), .TW(TW), .LANES(LANES), .RW(RW)) u_table (
        .clk(clk), .rst_n(rst_n), .commit(commit), .lane_vld(lane_vld),
        .dst_use(dst_use), .dst_reg(dst_reg_a), .alloc_tag(alloc_a),
        .retire_vld(retire_vld), .retire_tag(retire_tag),
        .ent_valid(ent_valid), .ent_tag(ent_tag)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        rmt_lookup #(.NUM(ARCH_REGS), .ROB(ROB_ENTRIES), .TW(TW), .LANES(LANES), .RW(RW), .K(k)) u_a (
            .clk(clk), .rst_n(rst_n), .src_use(srca_use[k]), .src_reg(srca_reg_a[k]),
            .ent_valid(ent_valid), .ent_tag(ent_tag), .rob_rdy(rob_ready_vec),
            .lane_vld(lane_vld), .dst_use(dst_use), .dst_reg(dst_reg_a), .alloc_tag(alloc_a),
            .mapped(srca_mapped[k]), .tag(srca_tag[k*TW +: TW]), .rdy(srca_rdy[k])
        );
        rmt_lookup #(.NUM(ARCH_REGS), .ROB(ROB_ENTRIES), .TW(TW), .LANES(LANES), .RW(RW), .K(k)) u_b (
            .clk(clk), .rst_n(rst_n), .src_use(srcb_use[k]), .src_reg(srcb_reg_a[k]),
            .ent_valid(ent_valid), .ent_tag(ent_tag), .rob_rdy(rob_ready_vec),
            .lane_vld(lane_vld), .dst_use(dst_use), .dst_reg(dst_reg_a), .alloc_tag(alloc_a),
            .mapped(srcb_mapped[k]), .tag(srcb_tag[k*TW +: TW]), .rdy(srcb_rdy[k])
        );
    end

    if (LANES >= 2) begin : g_fwd_chk
        assert_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_vld[0] && dst_use[0] && srca_use[1] && srca_reg_a[1] < RW'(ARCH_REGS)
             && dst_reg_a[0] == srca_reg_a[1])
            |-> (srca_mapped[1] && !srca_rdy[1] && srca_tag[TW +: TW] == alloc_a[0]));
    end
endmodule

// File: tb/rename_map_test.sv
module rename_map_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM = 67;
    localparam int ROB = 16;
    localparam int L   = 2;
    localparam int TW  = 4;
    localparam int RW  = 7;

    logic clk = 0, rst_n = 0;
    logic ren_go, ren_grant, retire_vld;
    logic [L-1:0] lane_vld, srca_use, srcb_use, dst_use;
    logic [L*RW-1:0] srca_reg, srcb_reg, dst_reg;
    logic [L*TW-1:0] alloc_tag;
    logic [ROB-1:0] rob_ready_vec;
    logic [TW-1:0] retire_tag;
    logic [L-1:0] srca_mapped, srca_rdy, srcb_mapped, srcb_rdy;
    logic [L*TW-1:0] srca_tag, srcb_tag;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    bit ref_v[NUM];
    logic [TW-1:0] ref_t[NUM];

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_map #(.ARCH_REGS(NUM), .ROB_ENTRIES(ROB), .LANES(L)) uut (.*);

    task automatic idle_inputs();
        ren_go = 0; ren_grant = 0; retire_vld = 0; retire_tag = '0;
        lane_vld = '0; srca_use = '0; srcb_use = '0; dst_use = '0;
        srca_reg = '0; srcb_reg = '0; dst_reg = '0; alloc_tag = '0; rob_ready_vec = '0;
    endtask

    task automatic set_lane(int k, bit v, bit ua, int ra, bit ub, int rb, bit ud, int rd, int t);
        lane_vld[k] = v; srca_use[k] = ua; srca_reg[k*RW +: RW] = RW'(ra);
        srcb_use[k] = ub; srcb_reg[k*RW +: RW] = RW'(rb);
        dst_use[k] = ud; dst_reg[k*RW +: RW] = RW'(rd); alloc_tag[k*TW +: TW] = TW'(t);
    endtask

    // Expected lookup from the requirements (R1, R2, R3, R5, R9)
    task automatic expect_src(int k, bit use_s, logic [RW-1:0] rg,
                              output bit m, output logic [TW-1:0] t, output bit r);
        m = 0; t = '0; r = 1;
        if (use_s && rg < NUM) begin
            if (ref_v[rg]) begin m = 1; t = ref_t[rg]; r = rob_ready_vec[ref_t[rg]]; end
            for (int j = 0; j < k; j++)
                if (lane_vld[j] && dst_use[j] && dst_reg[j*RW +: RW] == rg) begin
                    m = 1; t = alloc_tag[j*TW +: TW]; r = 0;
                end
        end
    endtask

    task automatic compare(string req, string nm, int k, bit am, logic [TW-1:0] at, bit ar,
                           bit em, logic [TW-1:0] et, bit er);
        n_checks++;
        if (am !== em || at !== et || ar !== er) begin
            n_fail++;
            $display("FAIL %s lane%0d %s: got mapped=%0d tag=%0d rdy=%0d, expected mapped=%0d tag=%0d rdy=%0d",
                     req, k, nm, am, at, ar, em, et, er);
        end
    endtask

    // Inputs already driven after a negedge; check, clock, update model.
    task automatic step(string req);
        bit m; logic [TW-1:0] t; bit r;
        #1;
        for (int k = 0; k < L; k++) begin
            expect_src(k, srca_use[k], srca_reg[k*RW +: RW], m, t, r);
            compare(req, "srcA", k, srca_mapped[k], srca_tag[k*TW +: TW], srca_rdy[k], m, t, r);
            expect_src(k, srcb_use[k], srcb_reg[k*RW +: RW], m, t, r);
            compare(req, "srcB", k, srcb_mapped[k], srcb_tag[k*TW +: TW], srcb_rdy[k], m, t, r);
        end
        @(posedge clk);
        // R6 clear first, then R4/R8 writes in lane order (R5 later lane wins)
        if (retire_vld)
            for (int x = 0; x < NUM; x++)
                if (ref_v[x] && ref_t[x] == retire_tag) ref_v[x] = 0;
        if (ren_go && ren_grant)
            for (int k = 0; k < L; k++)
                if (lane_vld[k] && dst_use[k] && dst_reg[k*RW +: RW] < NUM) begin
                    ref_v[dst_reg[k*RW +: RW]] = 1;
                    ref_t[dst_reg[k*RW +: RW]] = alloc_tag[k*TW +: TW];
                end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic int pick_reg();
        int s = int'($urandom % 16);
        if (s == 0) return int'($urandom % 128);
        if (s == 1) return NUM - 1;
        return int'($urandom % 8);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int x = 0; x < NUM; x++) begin ref_v[x] = 0; ref_t[x] = '0; end
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: all unmapped after reset
        set_lane(0, 1, 1, 0, 1, 3, 0, 0, 0);
        set_lane(1, 1, 1, 66, 1, 12, 0, 0, 0);
        step("R1");

        // R4: commit mappings r5->3, r6->4
        idle_inputs(); ren_go = 1; ren_grant = 1;
        set_lane(0, 1, 0, 0, 0, 0, 1, 5, 3);
        set_lane(1, 1, 0, 0, 0, 0, 1, 6, 4);
        step("R4");

        // R3: read back with mixed ready bits
        idle_inputs(); rob_ready_vec = 16'h0008;
        set_lane(0, 1, 1, 5, 1, 6, 0, 0, 0);
        set_lane(1, 1, 1, 6, 0, 5, 0, 0, 0);
        step("R3");

        // R5: in-bundle forwarding, both lanes write r10
        idle_inputs(); ren_go = 1; ren_grant = 1; rob_ready_vec = '1;
        set_lane(0, 1, 1, 9, 0, 0, 1, 10, 7);
        set_lane(1, 1, 1, 10, 1, 5, 1, 10, 8);
        step("R5");
        idle_inputs();
        set_lane(0, 1, 1, 10, 0, 0, 0, 0, 0);
        step("R5");

        // R7: no grant leaves table alone
        idle_inputs(); ren_go = 1; ren_grant = 0;
        set_lane(0, 1, 0, 0, 0, 0, 1, 5, 9);
        step("R7");
        idle_inputs();
        set_lane(0, 1, 1, 5, 1, 6, 0, 0, 0);
        step("R7");

        // R6: retire tag 3 clears r5 only
        idle_inputs(); retire_vld = 1; retire_tag = 4'd3;
        step("R6");
        idle_inputs();
        set_lane(0, 1, 1, 5, 1, 6, 0, 0, 0);
        step("R6");

        // R8: retire tag 4 while lane0 remaps r6 to 11
        idle_inputs(); ren_go = 1; ren_grant = 1; retire_vld = 1; retire_tag = 4'd4;
        set_lane(0, 1, 0, 0, 0, 0, 1, 6, 11);
        step("R8");
        idle_inputs();
        set_lane(0, 1, 1, 6, 0, 0, 0, 0, 0);
        step("R8");

        // R9: out-of-range register
        idle_inputs(); ren_go = 1; ren_grant = 1;
        set_lane(0, 1, 0, 0, 0, 0, 1, 70, 2);
        set_lane(1, 1, 1, 70, 1, 127, 0, 0, 0);
        step("R9");
        idle_inputs();
        set_lane(0, 1, 1, 70, 1, 5, 0, 0, 0);
        step("R9");

        // R2/R3/R4/R5/R6/R8: random mix
        for (int i = 0; i < 3000; i++) begin
            idle_inputs();
            ren_go = ($urandom % 10) < 7; ren_grant = ($urandom % 10) < 7;
            retire_vld = $urandom % 2; retire_tag = TW'($urandom);
            rob_ready_vec = ROB'($urandom);
            for (int k = 0; k < L; k++)
                set_lane(k, ($urandom % 8) != 0, $urandom % 2, pick_reg(), $urandom % 2, pick_reg(),
                         ($urandom % 4) != 0, pick_reg(), int'($urandom % ROB));
            step("R2/R3/R4/R5/R6/R8 random");
        end

        finish_run();
    end
endmodule